// File: doc/BRIEF.md
# Reversible Page Table Hash Unit

This unit turns a virtual address, a region identifier and the region's preferred page size into two values. The first is the address of an entry in a hashed page table. The second is a tag that is stored in that entry and compared on lookup. The table base address and the log2 size of the table in bytes come from a table control register and reach the unit as plain inputs. Table entries are 32 bytes wide. The virtual page number is always formed from the preferred page size, even when the actual page is larger. This keeps the hash and the tag consistent for every page that lies in one region.

The hash is a bitwise XOR of fields, so no information is lost. A second, independent path takes a full hash index, a tag and a page size, and rebuilds the region identifier, the virtual page number and the page-aligned virtual address. Verification logic, or software that manages the table, can use this path to confirm that an index and a tag pair with exactly one translation. Both paths register their results one cycle after an input strobe, and each result comes with its own done strobe.

Top module: `pt_hash_unit`

## Requirements
- R1: `fw_done` is high in exactly the cycle after `fw_valid` was sampled high. The forward result outputs change only on such a cycle and otherwise hold their values. While `rst` is high, every output is driven to zero.
- R2: The virtual page number is `fw_vaddr` shifted right by the clamped page size, kept to 36 bits. `fw_hash_idx` equals VPN bits 17:0 XOR `fw_rid`.
- R3: `fw_tag` bit 36 (the tag-invalid bit) is 0. Bits 35:18 hold `fw_rid` XOR VPN bits 35:18. Bits 17:0 hold VPN bits 35:18.
- R4: `fw_entry_addr` is built in two parts. The bits at and above the clamped table size come from `tbl_base`. The bits below it are the hash index shifted left by 5 and masked to the table size. As a result, bits 4:0 of the address are always zero.
- R5: A table size below 15 is treated as 15, and a size above 23 is treated as 23. In both cases `fw_size_err` is set with the result. A size from 15 to 23 gives `fw_size_err` = 0.
- R6: A page size below 12 is treated as 12, and a page size above 28 is treated as 28. In both cases `fw_pg_err` is set with the result. A page size from 12 to 28 gives `fw_pg_err` = 0.
- R7: `rv_done` is high in exactly the cycle after `rv_valid_in` was sampled high. The reverse outputs change only then.
- R8: Suppose a forward index and tag, made with a legal page size, are fed back through the reverse path with that same page size. Then `rv_rid` equals the original region identifier, and `rv_vpn` equals the original virtual page number. `rv_vbase` equals the original address with the bits below the page size cleared.
- R9: `rv_ti_err` reports bit 36 of `rv_tag`. The rebuild of `rv_rid`, `rv_vpn` and `rv_vbase` uses bits 35:0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_valid | input | 1 | Forward request strobe |
| fw_vaddr | input | 48 | Virtual address |
| fw_rid | input | 18 | Region identifier |
| fw_pg_log2 | input | 6 | Preferred page size, log2 bytes |
| tbl_base | input | 48 | Hashed table base address |
| tbl_size_log2 | input | 6 | Table size, log2 bytes |
| rv_valid_in | input | 1 | Reverse request strobe |
| rv_index | input | 18 | Full hash index to invert |
| rv_tag | input | 37 | Tag to invert |
| rv_pg_log2 | input | 6 | Page size for the reverse path |
| fw_done | output | 1 | Forward result strobe |
| fw_entry_addr | output | 48 | Table entry address |
| fw_hash_idx | output | 18 | Full hash index |
| fw_tag | output | 37 | Translation tag |
| fw_size_err | output | 1 | Table size was clamped |
| fw_pg_err | output | 1 | Page size was clamped |
| rv_done | output | 1 | Reverse result strobe |
| rv_rid | output | 18 | Rebuilt region identifier |
| rv_vpn | output | 36 | Rebuilt virtual page number |
| rv_vbase | output | 48 | Rebuilt page-aligned virtual address |
| rv_ti_err | output | 1 | Presented tag had its invalid bit set |

## Verification
The properties assume that `rst` is held for at least one clock edge before the first strobe. They also assume that inputs are stable around the sampling edge, and that the reverse page size matches the one that produced the tag. The stimulus drives every input on the falling edge. It sends table sizes from 10 to 30 and page sizes from 8 to 31, so both clamps and the legal interior are covered. The reverse path is always fed from independently generated forward values with a legal page size. This lets the round trip be judged against the original region identifier and address rather than against another formula.

// File: rtl/pt_hash_pkg.sv
package pt_hash_pkg;

  localparam int PG_MIN   = 12;
  localparam int PG_MAX   = 28;
  localparam int TSZ_MIN  = 15;
  localparam int ENT_LOG2 = 5;

  typedef struct packed {
    logic       err;
    logic [5:0] val;
  } clamp_t;

  function automatic clamp_t clamp6(input logic [5:0] v,
                                    input logic [5:0] lo,
                                    input logic [5:0] hi);
    clamp_t r;
    r.err = 1'b0;
    r.val = v;
    if (v < lo) begin
      r.val = lo;
      r.err = 1'b1;
    end else if (v > hi) begin
      r.val = hi;
      r.err = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/pth_fwd.sv
module pth_fwd #(
  parameter int VA_W  = 48,
  parameter int RID_W = 18
) (
  input  logic [VA_W-1:0]                           vaddr,
  input  logic [RID_W-1:0]                          rid,
  input  logic [5:0]                                pg,
  output logic [RID_W-1:0]                          idx,
  output logic [1+RID_W+(VA_W-pt_hash_pkg::PG_MIN-RID_W)-1:0] tag
);
  localparam int VPN_W = VA_W - pt_hash_pkg::PG_MIN;
  localparam int HI_W  = VPN_W - RID_W;

  logic [VPN_W-1:0] vpn;
  logic [HI_W-1:0]  hi;
  logic [RID_W-1:0] mix;

  always_comb begin
    vpn = VPN_W'(vaddr >> pg);
    hi  = vpn[VPN_W-1:RID_W];
    idx = vpn[RID_W-1:0] ^ rid;
  end

  for (genvar i = 0; i < RID_W; i++) begin : g_mix
    assign mix[i] = rid[i] ^ hi[i];
  end

  assign tag = {1'b0, mix, hi};

endmodule

// File: rtl/pth_addr.sv
module pth_addr #(
  parameter int VA_W  = 48,
  parameter int RID_W = 18
) (
  input  logic [VA_W-1:0]  base,
  input  logic [5:0]       tsz,
  input  logic [RID_W-1:0] idx,
  output logic [VA_W-1:0]  addr
);
  logic [VA_W-1:0] tmask;
  logic [VA_W-1:0] off;

  always_comb begin
    tmask = (VA_W'(1) << tsz) - VA_W'(1);
    off   = VA_W'(idx) << pt_hash_pkg::ENT_LOG2;
    addr  = (base & ~tmask) | (off & tmask);
  end

endmodule

// File: rtl/pth_rev.sv
module pth_rev #(
  parameter int VA_W  = 48,
  parameter int RID_W = 18
) (
  input  logic [RID_W-1:0]                    idx,
  input  logic [VA_W-pt_hash_pkg::PG_MIN-1:0] tag_body,
  input  logic [5:0]                          pg,
  output logic [RID_W-1:0]                    rid,
  output logic [VA_W-pt_hash_pkg::PG_MIN-1:0] vpn,
  output logic [VA_W-1:0]                     vbase
);
  localparam int VPN_W = VA_W - pt_hash_pkg::PG_MIN;
  localparam int HI_W  = VPN_W - RID_W;

  logic [HI_W-1:0]  hi;
  logic [RID_W-1:0] mix;

  always_comb begin
    hi    = tag_body[HI_W-1:0];
    mix   = tag_body[VPN_W-1:HI_W];
    rid   = mix ^ hi[RID_W-1:0];
    vpn   = {hi, idx ^ rid};
    vbase = VA_W'(vpn) << pg;
  end

endmodule

// File: rtl/pt_hash_unit.sv
module pt_hash_unit #(
  parameter int VA_W  = 48,
  parameter int RID_W = 18
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   fw_valid,
  input  logic [VA_W-1:0]                        fw_vaddr,
  input  logic [RID_W-1:0]                       fw_rid,
  input  logic [5:0]                             fw_pg_log2,
  input  logic [VA_W-1:0]                        tbl_base,
  input  logic [5:0]                             tbl_size_log2,
  input  logic                                   rv_valid_in,
  input  logic [RID_W-1:0]                       rv_index,
  input  logic [VA_W-pt_hash_pkg::PG_MIN:0]      rv_tag,
  input  logic [5:0]                             rv_pg_log2,
  output logic                                   fw_done,
  output logic [VA_W-1:0]                        fw_entry_addr,
  output logic [RID_W-1:0]                       fw_hash_idx,
  output logic [VA_W-pt_hash_pkg::PG_MIN:0]      fw_tag,
  output logic                                   fw_size_err,
  output logic                                   fw_pg_err,
  output logic                                   rv_done,
  output logic [RID_W-1:0]                       rv_rid,
  output logic [VA_W-pt_hash_pkg::PG_MIN-1:0]    rv_vpn,
  output logic [VA_W-1:0]                        rv_vbase,
  output logic                                   rv_ti_err
);
  import pt_hash_pkg::*;

  localparam int VPN_W   = VA_W - PG_MIN;
  localparam int TAG_W   = VPN_W + 1;
  localparam int TSZ_MAX = RID_W + ENT_LOG2;

  clamp_t pg_c, ts_c, rpg_c;

  always_comb begin
    pg_c  = clamp6(fw_pg_log2,    6'(PG_MIN),  6'(PG_MAX));
    ts_c  = clamp6(tbl_size_log2, 6'(TSZ_MIN), 6'(TSZ_MAX));
    rpg_c = clamp6(rv_pg_log2,    6'(PG_MIN),  6'(PG_MAX));
  end

  logic [RID_W-1:0] idx_n;
  logic [TAG_W-1:0] tag_n;
  logic [VA_W-1:0]  addr_n;
  logic [RID_W-1:0] rrid_n;
  logic [VPN_W-1:0] rvpn_n;
  logic [VA_W-1:0]  rvb_n;

  pth_fwd #(.VA_W(VA_W), .RID_W(RID_W)) u_fwd (
    .vaddr (fw_vaddr),
    .rid   (fw_rid),
    .pg    (pg_c.val),
    .idx   (idx_n),
    .tag   (tag_n)
  );

  pth_addr #(.VA_W(VA_W), .RID_W(RID_W)) u_addr (
    .base  (tbl_base),
    .tsz   (ts_c.val),
    .idx   (idx_n),
    .addr  (addr_n)
  );

  pth_rev #(.VA_W(VA_W), .RID_W(RID_W)) u_rev (
    .idx      (rv_index),
    .tag_body (rv_tag[TAG_W-2:0]),
    .pg       (rpg_c.val),
    .rid      (rrid_n),
    .vpn      (rvpn_n),
    .vbase    (rvb_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_done       <= 1'b0;
      fw_entry_addr <= '0;
      fw_hash_idx   <= '0;
      fw_tag        <= '0;
      fw_size_err   <= 1'b0;
      fw_pg_err     <= 1'b0;
    end else begin
      fw_done <= fw_valid;
      if (fw_valid) begin
        fw_entry_addr <= addr_n;
        fw_hash_idx   <= idx_n;
        fw_tag        <= tag_n;
        fw_size_err   <= ts_c.err;
        fw_pg_err     <= pg_c.err;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_done   <= 1'b0;
      rv_rid    <= '0;
      rv_vpn    <= '0;
      rv_vbase  <= '0;
      rv_ti_err <= 1'b0;
    end else begin
      rv_done <= rv_valid_in;
      if (rv_valid_in) begin
        rv_rid    <= rrid_n;
        rv_vpn    <= rvpn_n;
        rv_vbase  <= rvb_n;
        rv_ti_err <= rv_tag[TAG_W-1];
      end
    end
  end

endmodule

// File: rtl/pth_chk.sv
module pth_chk #(
  parameter int VA_W  = 48,
  parameter int RID_W = 18
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              fw_valid,
  input logic [5:0]                        fw_pg_log2,
  input logic [5:0]                        tbl_size_log2,
  input logic                              rv_valid_in,
  input logic                              fw_done,
  input logic [VA_W-1:0]                   fw_entry_addr,
  input logic [VA_W-pt_hash_pkg::PG_MIN:0] fw_tag,
  input logic                              fw_size_err,
  input logic                              fw_pg_err,
  input logic                              rv_done
);
  localparam int TAG_W = VA_W - pt_hash_pkg::PG_MIN + 1;

  a_r1_done_follows: assert property (@(posedge clk) disable iff (rst)
    fw_valid |=> fw_done);

  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !fw_valid |=> !fw_done);

  a_r1_tag_holds: assert property (@(posedge clk) disable iff (rst)
    !fw_valid |=> $stable(fw_tag));

  a_r3_ti_clear: assert property (@(posedge clk) disable iff (rst)
    fw_done |-> !fw_tag[TAG_W-1]);

  a_r4_entry_aligned: assert property (@(posedge clk) disable iff (rst)
    fw_done |-> (fw_entry_addr[pt_hash_pkg::ENT_LOG2-1:0] == '0));

  a_r5_small_table_flag: assert property (@(posedge clk) disable iff (rst)
    (fw_valid && tbl_size_log2 < 6'(pt_hash_pkg::TSZ_MIN)) |=> fw_size_err);

  a_r6_small_page_flag: assert property (@(posedge clk) disable iff (rst)
    (fw_valid && fw_pg_log2 < 6'(pt_hash_pkg::PG_MIN)) |=> fw_pg_err);

  a_r7_rev_done: assert property (@(posedge clk) disable iff (rst)
    rv_valid_in |=> rv_done);

  a_r7_rev_quiet: assert property (@(posedge clk) disable iff (rst)
    !rv_valid_in |=> !rv_done);

endmodule

bind pt_hash_unit pth_chk #(.VA_W(VA_W), .RID_W(RID_W)) u_chk (.*);

// File: tb/test_pt_hash_unit.sv
module test_pt_hash_unit;
  localparam int VA_W  = 48;
  localparam int RID_W = 18;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        fw_valid = 1'b0;
  logic [47:0] fw_vaddr = '0;
  logic [17:0] fw_rid = '0;
  logic [5:0]  fw_pg_log2 = 6'd12;
  logic [47:0] tbl_base = '0;
  logic [5:0]  tbl_size_log2 = 6'd15;
  logic        rv_valid_in = 1'b0;
  logic [17:0] rv_index = '0;
  logic [36:0] rv_tag = '0;
  logic [5:0]  rv_pg_log2 = 6'd12;
  logic        fw_done, fw_size_err, fw_pg_err, rv_done, rv_ti_err;
  logic [47:0] fw_entry_addr, rv_vbase;
  logic [17:0] fw_hash_idx, rv_rid;
  logic [36:0] fw_tag;
  logic [35:0] rv_vpn;

  pt_hash_unit #(.VA_W(VA_W), .RID_W(RID_W)) i_pt_hash_unit (.*);

  int total = 0;
  int bad   = 0;
  int wd    = 0;

  // expected register images
  logic [63:0] e_fdone, e_addr, e_idx, e_tag, e_serr, e_perr;
  logic [63:0] e_rdone, e_rid, e_vpn, e_vbase, e_ti;
  // pending reverse expectations (the originals)
  logic [63:0] p_rid = 0, p_vpn = 0, p_vbase = 0, p_ti = 0;

  function automatic logic [63:0] lm(int n);
    logic [63:0] m = '0;
    for (int b = 0; b < 64; b++) if (b < n) m[b] = 1'b1;
    return m;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_fwd(input logic [63:0] va, input logic [63:0] rid,
                           input int ps, input logic [63:0] base, input int ts,
                           output logic [63:0] idx, output logic [63:0] tag,
                           output logic [63:0] addr, output logic [63:0] serr,
                           output logic [63:0] perr, output logic [63:0] vpn);
    int pc, tc;
    logic [63:0] hi;
    pc = ps; perr = 0;
    if (ps < 12) begin pc = 12; perr = 1; end
    if (ps > 28) begin pc = 28; perr = 1; end
    tc = ts; serr = 0;
    if (ts < 15) begin tc = 15; serr = 1; end
    if (ts > 23) begin tc = 23; serr = 1; end
    vpn  = (va >> pc) & lm(36);
    idx  = (vpn ^ rid) & lm(18);
    hi   = (vpn >> 18) & lm(18);
    tag  = (((rid ^ hi) & lm(18)) << 18) | hi;
    addr = (base & ~lm(tc) & lm(48)) | ((idx << 5) & lm(tc));
  endtask

  task automatic set_fw(logic [47:0] va, logic [17:0] rid, int ps, logic [47:0] base, int ts);
    fw_valid = 1'b1; fw_vaddr = va; fw_rid = rid;
    fw_pg_log2 = 6'(ps); tbl_base = base; tbl_size_log2 = 6'(ts);
  endtask

  task automatic set_rv(logic [47:0] va, logic [17:0] rid, int ps, bit ti);
    logic [63:0] i, t, a, s, p, v;
    model_fwd({16'h0, va}, {46'h0, rid}, ps, 64'h0, 20, i, t, a, s, p, v);
    rv_valid_in = 1'b1;
    rv_index = i[17:0];
    rv_tag = {ti, t[35:0]};
    rv_pg_log2 = 6'(ps);
    p_rid = {46'h0, rid};
    p_vpn = v;
    p_vbase = {16'h0, va} & ~lm(ps);
    p_ti = {63'h0, ti};
  endtask

  task automatic tick();
    logic [63:0] i, t, a, s, p, v;
    if (rst) begin
      e_fdone = 0; e_addr = 0; e_idx = 0; e_tag = 0; e_serr = 0; e_perr = 0;
      e_rdone = 0; e_rid = 0; e_vpn = 0; e_vbase = 0; e_ti = 0;
    end else begin
      e_fdone = {63'h0, fw_valid};
      if (fw_valid) begin
        model_fwd({16'h0, fw_vaddr}, {46'h0, fw_rid}, int'(fw_pg_log2),
                  {16'h0, tbl_base}, int'(tbl_size_log2), i, t, a, s, p, v);
        e_idx = i; e_tag = t; e_addr = a; e_serr = s; e_perr = p;
      end
      e_rdone = {63'h0, rv_valid_in};
      if (rv_valid_in) begin
        e_rid = p_rid; e_vpn = p_vpn; e_vbase = p_vbase; e_ti = p_ti;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R1", "fw_done",     {63'h0, fw_done},      e_fdone);
    chk("R2", "hash_idx",    {46'h0, fw_hash_idx},  e_idx);
    chk("R3", "tag",         {27'h0, fw_tag},       e_tag);
    chk("R3", "ti_bit",      {63'h0, fw_tag[36]},   64'h0);
    chk("R4", "entry_addr",  {16'h0, fw_entry_addr}, e_addr);
    chk("R5", "size_err",    {63'h0, fw_size_err},  e_serr);
    chk("R6", "pg_err",      {63'h0, fw_pg_err},    e_perr);
    chk("R7", "rv_done",     {63'h0, rv_done},      e_rdone);
    chk("R8", "rv_rid",      {46'h0, rv_rid},       e_rid);
    chk("R8", "rv_vpn",      {28'h0, rv_vpn},       e_vpn);
    chk("R8", "rv_vbase",    {16'h0, rv_vbase},     e_vbase);
    chk("R9", "rv_ti_err",   {63'h0, rv_ti_err},    e_ti);
  endtask

  task automatic idle();
    fw_valid = 1'b0;
    rv_valid_in = 1'b0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state (R1, R7)
    @(negedge clk);
    tick(); tick(); tick();
    rst = 1'b0;

    // R2/R3/R4 basic forward, legal sizes
    set_fw(48'h1234_5678_9ABC, 18'h2A5A5, 12, 48'h7FF0_0000_0000, 15); tick();
    idle(); tick(); tick();               // R1 hold, no done
    set_fw(48'hFFFF_FFFF_FFFF, 18'h3FFFF, 16, 48'hABCD_EF12_3456, 20); tick();
    // R5 table size clamps and boundaries
    set_fw(48'h0000_DEAD_B000, 18'h00011, 14, 48'h1111_2222_3333, 10); tick();
    set_fw(48'h0000_DEAD_B000, 18'h00011, 14, 48'h1111_2222_3333, 23); tick();
    set_fw(48'h0000_DEAD_B000, 18'h00011, 14, 48'h1111_2222_3333, 40); tick();
    // R6 page size clamps and boundaries
    set_fw(48'h8000_0001_2345, 18'h15555, 5,  48'h4000_0000_0000, 18); tick();
    set_fw(48'h8000_0001_2345, 18'h15555, 28, 48'h4000_0000_0000, 18); tick();
    set_fw(48'h8000_0001_2345, 18'h15555, 35, 48'h4000_0000_0000, 18); tick();
    idle(); tick();
    // R8 round trips at several page sizes, R9 ti reporting
    set_rv(48'h1234_5678_9ABC, 18'h2A5A5, 12, 1'b0); tick();
    set_rv(48'hFEDC_BA98_7654, 18'h0F0F0, 16, 1'b0); tick();
    set_rv(48'hFFFF_FFFF_FFFF, 18'h3FFFF, 28, 1'b0); tick();
    set_rv(48'h0003_0000_0000, 18'h00001, 20, 1'b1); tick();
    idle(); tick(); tick();               // R7 hold

    // random traffic on both paths
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      if ($urandom_range(0, 9) < 7)
        set_fw(r[47:0], 18'($urandom), $urandom_range(8, 31),
               {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, $urandom_range(10, 30));
      else
        fw_valid = 1'b0;
      if ($urandom_range(0, 9) < 6)
        set_rv({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, 18'($urandom),
               $urandom_range(12, 28), bit'($urandom_range(0, 7) == 0));
      else
        rv_valid_in = 1'b0;
      tick();
    end
    idle(); tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule